// File: doc/BRIEF.md
# Trap and Interrupt Context Sequencer

This block runs the multi-cycle entry and exit of exception handling for a small 16-bit processor. At each instruction boundary the fetch unit offers it the instruction specifier of the instruction about to run, along with the current register values and the interrupt line. Three events start a sequence. A specifier with an unimplemented opcode raises a trap. The return-from-handler specifier starts a restore. An unmasked interrupt request starts an interrupt entry.

On entry the sequencer captures seven context words and writes them one per memory access onto a stack that grows toward lower addresses. It then reads the handler address from a fixed vector word. In the same cycle it loads that address into the program counter and loads the stack pointer with the new top of stack. An interrupt entry also sets the interrupt mask. On return it reads six words back from the stack pointer upward, restoring flags and mask, A, X, B, PC and finally SP. Every register load is a value plus a one-cycle load strobe. The fetch unit sees `busy_o` from the boundary cycle onward and a `done_o` pulse when the sequence is over.

Top module: `exc_ctx_seq`

## Requirements
- R1: With `bnd_i` high and the sequencer idle, a specifier whose top five bits are 29, 30 or 31 (binary 11101, 11110, 11111) starts a trap. Any other specifier that is not the return code, with no accepted interrupt, starts nothing: `busy_o` stays low and no memory request is made.
- R2: Trap and interrupt entry write seven words at SP-2, SP-4 and so on down to SP-14, in this order: the specifier zero-extended, SP, PC, B, X, A, then the flags word. The flags word holds NZVC in bits 3..0, the interrupt mask in bit 4, and zero elsewhere.
- R3: After the last write, one read is made at address 0x0FFE. One cycle after that read is acknowledged, PC is loaded with the read word, SP is loaded with SP-14, and `done_o` pulses, all in the same cycle.
- R4: Specifier 0x01 starts a return. It makes six reads at SP, SP+2, up to SP+10, restoring in this order: flags (bits 3..0), A, X, B, PC and SP. The mask is restored from bit 4 together with the flags. Each load strobe comes one cycle after its read acknowledge, and `done_o` comes with the SP load.
- R5: An interrupt request is taken only in a cycle with `bnd_i` high while `imask_i` is 0. A request without a boundary, or with the mask set, has no effect.
- R6: An interrupt entry stacks the same frame as R2, with the current mask (0) in bit 4 of the flags word. It loads the mask with 1 in the same cycle as the PC load. A trap leaves the mask untouched.
- R7: A trap or a return at the same boundary as an unmasked interrupt request takes precedence. The request is not taken and the mask is not loaded.
- R8: The memory port makes at most one access per cycle. A request holds its address, direction and data until `mem_ack_i`, and the sequence advances only on an acknowledge. A sequence of N accesses with L wait cycles each gives `done_o` 1+N*(L+1) cycles after the boundary cycle.
- R9: `busy_o` is high in the boundary cycle of an accepted event and stays high through the cycle of the final acknowledge. `done_o` is a single-cycle pulse in the cycle after that.
- R10: During and after reset, `busy_o`, `done_o`, `mem_req_o` and all load strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bnd_i | input | 1 | Instruction boundary strobe |
| spec_i | input | 8 | Instruction specifier at the boundary |
| irq_i | input | 1 | Interrupt request level |
| imask_i | input | 1 | Current interrupt mask |
| sp_i | input | 16 | Current stack pointer |
| pc_i | input | 16 | Current program counter |
| a_i | input | 16 | Current A register |
| x_i | input | 16 | Current X register |
| b_i | input | 16 | Current B register |
| flags_i | input | 4 | Current NZVC flags |
| busy_o | output | 1 | Sequence active; fetch must wait |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 16 | Byte address of the access |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access acknowledge |
| sp_ld_o | output | 1 | Load strobe for SP |
| sp_o | output | 16 | Value for SP |
| pc_ld_o | output | 1 | Load strobe for PC |
| pc_o | output | 16 | Value for PC |
| a_ld_o | output | 1 | Load strobe for A |
| a_o | output | 16 | Value for A |
| x_ld_o | output | 1 | Load strobe for X |
| x_o | output | 16 | Value for X |
| b_ld_o | output | 1 | Load strobe for B |
| b_o | output | 16 | Value for B |
| flags_ld_o | output | 1 | Load strobe for NZVC |
| flags_o | output | 4 | Value for NZVC |
| imask_ld_o | output | 1 | Load strobe for the interrupt mask |
| imask_o | output | 1 | Value for the interrupt mask |

## Verification
`busy_o` is combinational in the boundary cycle. Every other result is registered: each load strobe comes one cycle after the acknowledge that carries its data, and `done_o` comes 1+N*(L+1) cycles after the boundary cycle, with N = 8 for an entry and N = 6 for a return. The bench drives inputs and samples outputs on the falling edge. It counts falling edges from the boundary until `done_o` and compares that count with the formula for the memory latency it programmed. It reads register values only from the strobes it logged, and memory contents only from the writes its memory model recorded.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  typedef enum logic [1:0] {EV_NONE, EV_TRAP, EV_RET, EV_IRQ} ev_kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_VEC, ST_POP} seq_state_e;

  localparam int FLAG_W   = 4;
  localparam int MASK_BIT = FLAG_W;

  localparam int FRAME_WORDS   = 7;
  localparam int RESTORE_WORDS = 6;

  // push slots, lowest slot written first (highest address)
  localparam int SLOT_SPEC  = 0;
  localparam int SLOT_SP    = 1;
  localparam int SLOT_PC    = 2;
  localparam int SLOT_B     = 3;
  localparam int SLOT_X     = 4;
  localparam int SLOT_A     = 5;
  localparam int SLOT_FLAGS = 6;

  // pop slots, read upward from the stack pointer
  localparam int POP_FLAGS = 0;
  localparam int POP_A     = 1;
  localparam int POP_X     = 2;
  localparam int POP_B     = 3;
  localparam int POP_PC    = 4;
  localparam int POP_SP    = 5;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_seq_pkg::*;
#(
  parameter int SPEC_W       = 8,
  parameter int OPC_W        = 5,
  parameter int TRAP_OPC_MIN = 29,
  parameter int RET_SPEC     = 1
) (
  input  logic              bnd_i,
  input  logic [SPEC_W-1:0] spec_i,
  input  logic              irq_i,
  input  logic              imask_i,
  output ev_kind_e          kind_o
);

  logic [OPC_W-1:0] opc;
  logic             is_trap;
  logic             is_ret;
  logic             irq_ok;

  assign opc     = spec_i[SPEC_W-1 -: OPC_W];
  assign is_trap = (opc >= OPC_W'(TRAP_OPC_MIN));
  assign is_ret  = (spec_i == SPEC_W'(RET_SPEC));
  assign irq_ok  = irq_i & ~imask_i;

  // R7: trap first, then return, then an unmasked request
  always_comb begin
    kind_o = EV_NONE;
    if (bnd_i) begin
      if (is_trap)     kind_o = EV_TRAP;
      else if (is_ret) kind_o = EV_RET;
      else if (irq_ok) kind_o = EV_IRQ;
    end
  end

endmodule

// File: rtl/exc_frame.sv
module exc_frame
  import exc_seq_pkg::*;
#(
  parameter int DW     = 16,
  parameter int SPEC_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en_i,
  input  logic [SPEC_W-1:0] spec_i,
  input  logic [DW-1:0]     sp_i,
  input  logic [DW-1:0]     pc_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     x_i,
  input  logic [DW-1:0]     b_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              imask_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DW-1:0]     word_o
);

  logic [DW-1:0] cap_w  [FRAME_WORDS];
  logic [DW-1:0] ctx_q  [FRAME_WORDS];

  always_comb begin
    cap_w[SLOT_SPEC]  = DW'(spec_i);
    cap_w[SLOT_SP]    = sp_i;
    cap_w[SLOT_PC]    = pc_i;
    cap_w[SLOT_B]     = b_i;
    cap_w[SLOT_X]     = x_i;
    cap_w[SLOT_A]     = a_i;
    cap_w[SLOT_FLAGS] = DW'({imask_i, flags_i});
  end

  for (genvar g = 0; g < FRAME_WORDS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctx_q[g] <= '0;
      else if (cap_en_i) ctx_q[g] <= cap_w[g];
    end
  end

  assign word_o = ctx_q[idx_i];

endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
  import exc_seq_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          IDX_W    = 3,
  parameter logic [15:0] VEC_ADDR = 16'h0FFE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ev_kind_e         ev_i,
  input  logic [DW-1:0]    sp_i,
  input  logic             ack_i,
  output logic             idle_o,
  output logic             cap_o,
  output logic             req_o,
  output logic             we_o,
  output logic [DW-1:0]    addr_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             pop_hit_o,
  output logic             vec_hit_o,
  output logic             irq_entry_o,
  output logic [DW-1:0]    top_o
);

  localparam logic [DW-1:0]    WB        = DW'(DW / 8);
  localparam logic [IDX_W-1:0] LAST_PUSH = IDX_W'(FRAME_WORDS - 1);
  localparam logic [IDX_W-1:0] LAST_POP  = IDX_W'(RESTORE_WORDS - 1);

  seq_state_e       state_q, state_d;
  ev_kind_e         kind_q, kind_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [DW-1:0]    ptr_q, ptr_d;

  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    idx_d     = idx_q;
    ptr_d     = ptr_q;
    cap_o     = 1'b0;
    req_o     = 1'b0;
    we_o      = 1'b0;
    addr_o    = ptr_q;
    pop_hit_o = 1'b0;
    vec_hit_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ev_i != EV_NONE) begin
          cap_o  = 1'b1;
          kind_d = ev_i;
          idx_d  = '0;
          if (ev_i == EV_RET) begin
            state_d = ST_POP;
            ptr_d   = sp_i;
          end else begin
            state_d = ST_PUSH;
            ptr_d   = sp_i - WB;
          end
        end
      end
      ST_PUSH: begin
        req_o = 1'b1;
        we_o  = 1'b1;
        if (ack_i) begin
          ptr_d = ptr_q - WB;
          if (idx_q == LAST_PUSH) begin
            state_d = ST_VEC;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_VEC: begin
        req_o  = 1'b1;
        addr_o = DW'(VEC_ADDR);
        if (ack_i) begin
          vec_hit_o = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      ST_POP: begin
        req_o = 1'b1;
        if (ack_i) begin
          pop_hit_o = 1'b1;
          ptr_d     = ptr_q + WB;
          if (idx_q == LAST_POP) begin
            state_d = ST_IDLE;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= EV_NONE;
      idx_q   <= '0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      idx_q   <= idx_d;
      ptr_q   <= ptr_d;
    end
  end

  assign idle_o      = (state_q == ST_IDLE);
  assign idx_o       = idx_q;
  assign irq_entry_o = (kind_q == EV_IRQ);
  // after the last push the pointer sits one word below the new top
  assign top_o       = ptr_q + WB;

endmodule

// File: rtl/exc_restore.sv
module exc_restore
  import exc_seq_pkg::*;
#(
  parameter int DW    = 16,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop_hit_i,
  input  logic              vec_hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DW-1:0]     rdata_i,
  input  logic [DW-1:0]     top_i,
  input  logic              irq_entry_i,
  output logic              done_o,
  output logic              sp_ld_o,
  output logic [DW-1:0]     sp_o,
  output logic              pc_ld_o,
  output logic [DW-1:0]     pc_o,
  output logic              a_ld_o,
  output logic [DW-1:0]     a_o,
  output logic              x_ld_o,
  output logic [DW-1:0]     x_o,
  output logic              b_ld_o,
  output logic [DW-1:0]     b_o,
  output logic              flags_ld_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              imask_ld_o,
  output logic              imask_o
);

  logic hit_flags, hit_a, hit_x, hit_b, hit_pc, hit_sp;
  logic en_sp, en_pc, en_mask, fin;
  logic [DW-1:0] sp_d, pc_d;
  logic          mask_d;

  always_comb begin
    hit_flags = pop_hit_i && (idx_i == IDX_W'(POP_FLAGS));
    hit_a     = pop_hit_i && (idx_i == IDX_W'(POP_A));
    hit_x     = pop_hit_i && (idx_i == IDX_W'(POP_X));
    hit_b     = pop_hit_i && (idx_i == IDX_W'(POP_B));
    hit_pc    = pop_hit_i && (idx_i == IDX_W'(POP_PC));
    hit_sp    = pop_hit_i && (idx_i == IDX_W'(POP_SP));
    en_sp     = hit_sp | vec_hit_i;
    en_pc     = hit_pc | vec_hit_i;
    en_mask   = hit_flags | (vec_hit_i & irq_entry_i);
    fin       = hit_sp | vec_hit_i;
    sp_d      = vec_hit_i ? top_i : rdata_i;
    pc_d      = rdata_i;
    mask_d    = vec_hit_i ? 1'b1 : rdata_i[MASK_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o     <= 1'b0;
      sp_ld_o    <= 1'b0;
      pc_ld_o    <= 1'b0;
      a_ld_o     <= 1'b0;
      x_ld_o     <= 1'b0;
      b_ld_o     <= 1'b0;
      flags_ld_o <= 1'b0;
      imask_ld_o <= 1'b0;
    end else begin
      done_o     <= fin;
      sp_ld_o    <= en_sp;
      pc_ld_o    <= en_pc;
      a_ld_o     <= hit_a;
      x_ld_o     <= hit_x;
      b_ld_o     <= hit_b;
      flags_ld_o <= hit_flags;
      imask_ld_o <= en_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_o    <= '0;
      pc_o    <= '0;
      a_o     <= '0;
      x_o     <= '0;
      b_o     <= '0;
      flags_o <= '0;
      imask_o <= 1'b0;
    end else begin
      if (en_sp)     sp_o    <= sp_d;
      if (en_pc)     pc_o    <= pc_d;
      if (hit_a)     a_o     <= rdata_i;
      if (hit_x)     x_o     <= rdata_i;
      if (hit_b)     b_o     <= rdata_i;
      if (hit_flags) flags_o <= rdata_i[FLAG_W-1:0];
      if (en_mask)   imask_o <= mask_d;
    end
  end

endmodule

// File: rtl/exc_ctx_seq.sv
module exc_ctx_seq
  import exc_seq_pkg::*;
#(
  parameter int          DW           = 16,
  parameter int          SPEC_W       = 8,
  parameter int          OPC_W        = 5,
  parameter int          TRAP_OPC_MIN = 29,
  parameter int          RET_SPEC     = 1,
  parameter logic [15:0] VEC_ADDR     = 16'h0FFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bnd_i,
  input  logic [SPEC_W-1:0] spec_i,
  input  logic              irq_i,
  input  logic              imask_i,
  input  logic [DW-1:0]     sp_i,
  input  logic [DW-1:0]     pc_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     x_i,
  input  logic [DW-1:0]     b_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              sp_ld_o,
  output logic [DW-1:0]     sp_o,
  output logic              pc_ld_o,
  output logic [DW-1:0]     pc_o,
  output logic              a_ld_o,
  output logic [DW-1:0]     a_o,
  output logic              x_ld_o,
  output logic [DW-1:0]     x_o,
  output logic              b_ld_o,
  output logic [DW-1:0]     b_o,
  output logic              flags_ld_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              imask_ld_o,
  output logic              imask_o
);

  localparam int IDX_W = $clog2(FRAME_WORDS);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  ev_kind_e         ev;
  logic             idle, cap, pop_hit, vec_hit, irq_entry;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    top;

  exc_classify #(
    .SPEC_W(SPEC_W), .OPC_W(OPC_W),
    .TRAP_OPC_MIN(TRAP_OPC_MIN), .RET_SPEC(RET_SPEC)
  ) u_classify (
    .bnd_i   (bnd_i & idle & rst_core_n),
    .spec_i  (spec_i),
    .irq_i   (irq_i),
    .imask_i (imask_i),
    .kind_o  (ev)
  );

  exc_seq_fsm #(.DW(DW), .IDX_W(IDX_W), .VEC_ADDR(VEC_ADDR)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .ev_i        (ev),
    .sp_i        (sp_i),
    .ack_i       (mem_ack_i),
    .idle_o      (idle),
    .cap_o       (cap),
    .req_o       (mem_req_o),
    .we_o        (mem_we_o),
    .addr_o      (mem_addr_o),
    .idx_o       (idx),
    .pop_hit_o   (pop_hit),
    .vec_hit_o   (vec_hit),
    .irq_entry_o (irq_entry),
    .top_o       (top)
  );

  exc_frame #(.DW(DW), .SPEC_W(SPEC_W), .IDX_W(IDX_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .cap_en_i (cap),
    .spec_i   (spec_i),
    .sp_i     (sp_i),
    .pc_i     (pc_i),
    .a_i      (a_i),
    .x_i      (x_i),
    .b_i      (b_i),
    .flags_i  (flags_i),
    .imask_i  (imask_i),
    .idx_i    (idx),
    .word_o   (mem_wdata_o)
  );

  exc_restore #(.DW(DW), .IDX_W(IDX_W)) u_restore (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .pop_hit_i   (pop_hit),
    .vec_hit_i   (vec_hit),
    .idx_i       (idx),
    .rdata_i     (mem_rdata_i),
    .top_i       (top),
    .irq_entry_i (irq_entry),
    .done_o      (done_o),
    .sp_ld_o     (sp_ld_o),
    .sp_o        (sp_o),
    .pc_ld_o     (pc_ld_o),
    .pc_o        (pc_o),
    .a_ld_o      (a_ld_o),
    .a_o         (a_o),
    .x_ld_o      (x_ld_o),
    .x_o         (x_o),
    .b_ld_o      (b_ld_o),
    .b_o         (b_o),
    .flags_ld_o  (flags_ld_o),
    .flags_o     (flags_o),
    .imask_ld_o  (imask_ld_o),
    .imask_o     (imask_o)
  );

  // R9: busy covers the boundary cycle of an accepted event
  assign busy_o = ~idle | (ev != EV_NONE);

endmodule

// File: rtl/exc_ctx_seq_chk.sv
module exc_ctx_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_addr_o,
  input logic          mem_ack_i,
  input logic          sp_ld_o,
  input logic          pc_ld_o
);

  a_r8_we_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_req_o);

  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  a_r2_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && mem_ack_i) |=>
      (!mem_we_o || mem_addr_o == $past(mem_addr_o) - DW'(DW / 8)));

  a_r9_req_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o);

  a_r9_end_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r4_sp_load_is_last: assert property (@(posedge clk) disable iff (!rst_n)
    sp_ld_o |-> done_o);

  a_r3_pc_with_done_or_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_ld_o && sp_ld_o) |-> done_o);

endmodule

bind exc_ctx_seq exc_ctx_seq_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_ack_i  (mem_ack_i),
  .sp_ld_o    (sp_ld_o),
  .pc_ld_o    (pc_ld_o)
);

// File: tb/exc_ctx_seq_tb.sv
`timescale 1ns/1ps
module exc_ctx_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bnd_i = 1'b0;
  logic [7:0]  spec_i = '0;
  logic        irq_i = 1'b0;
  logic        imask_i = 1'b0;
  logic [15:0] sp_i = '0, pc_i = '0, a_i = '0, x_i = '0, b_i = '0;
  logic [3:0]  flags_i = '0;
  logic        busy_o, done_o, mem_req_o, mem_we_o, mem_ack_i;
  logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        sp_ld_o, pc_ld_o, a_ld_o, x_ld_o, b_ld_o, flags_ld_o, imask_ld_o;
  logic [15:0] sp_o, pc_o, a_o, x_o, b_o;
  logic [3:0]  flags_o;
  logic        imask_o;

  always #10 clk = ~clk;

  exc_ctx_seq u_dut (.*);

  // memory model with programmable wait cycles
  logic [15:0] mem [0:4095];
  int          lat = 0;
  int          wcnt = 0;
  assign mem_ack_i   = mem_req_o && (wcnt == lat);
  assign mem_rdata_i = mem[mem_addr_o[12:1]];

  // logs of writes and register loads
  logic [15:0] wl_addr [0:255];
  logic [15:0] wl_data [0:255];
  int          wn = 0;
  int          ll_code [0:255];
  int          ln = 0;
  logic [15:0] v_sp, v_pc, v_a, v_x, v_b;
  logic [3:0]  v_flags;
  logic        v_mask;
  int          cyc = 0;

  int checks = 0;
  int errors = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req_o && !mem_ack_i) wcnt <= wcnt + 1;
    else                         wcnt <= 0;
    if (mem_req_o && mem_we_o && mem_ack_i) begin
      mem[mem_addr_o[12:1]] <= mem_wdata_o;
      wl_addr[wn[7:0]] <= mem_addr_o;
      wl_data[wn[7:0]] <= mem_wdata_o;
      wn <= wn + 1;
    end
    begin
      int k;
      k = ln;
      if (flags_ld_o) begin ll_code[k[7:0]] = 0; k++; v_flags <= flags_o; end
      if (imask_ld_o) begin ll_code[k[7:0]] = 6; k++; v_mask <= imask_o; end
      if (a_ld_o)     begin ll_code[k[7:0]] = 1; k++; v_a <= a_o; end
      if (x_ld_o)     begin ll_code[k[7:0]] = 2; k++; v_x <= x_o; end
      if (b_ld_o)     begin ll_code[k[7:0]] = 3; k++; v_b <= b_o; end
      if (pc_ld_o)    begin ll_code[k[7:0]] = 4; k++; v_pc <= pc_o; end
      if (sp_ld_o)    begin ll_code[k[7:0]] = 5; k++; v_sp <= sp_o; end
      ln <= k;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_ctx(input logic [15:0] sp, input logic [7:0] spec,
                         input logic irq, input logic mask, input logic [3:0] fl);
    sp_i = sp; spec_i = spec; irq_i = irq; imask_i = mask; flags_i = fl;
    pc_i = 16'h1234; a_i = 16'hA0A1; x_i = 16'h5A5A; b_i = 16'hB00B;
  endtask

  // pulse the boundary and count falling edges until done_o
  task automatic run_seq(input string req, input int exp_n);
    int n;
    int busy_cnt;
    #1;
    chk(req, "busy in boundary cycle", {31'b0, busy_o}, 32'd1);
    n = 0; busy_cnt = 1;
    for (int i = 1; i <= 300; i++) begin
      @(negedge clk);
      bnd_i = 1'b0;
      n = i;
      if (done_o) break;
      if (busy_o) busy_cnt++;
    end
    chk(req, "cycles to done", n, exp_n);
    chk(req, "busy cycles", busy_cnt, exp_n);
    chk("R9", "busy low with done", {31'b0, busy_o}, 32'd0);
    @(negedge clk);
    chk("R9", "done single pulse", {31'b0, done_o}, 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "busy in reset", {31'b0, busy_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10", "req after reset", {31'b0, mem_req_o}, 32'd0);
    chk("R10", "done after reset", {31'b0, done_o}, 32'd0);
    chk("R10", "strobes after reset",
        {25'b0, sp_ld_o, pc_ld_o, a_ld_o, x_ld_o, b_ld_o, flags_ld_o, imask_ld_o}, 32'd0);
  endtask

  // trap or interrupt entry; irq_kind selects the expected mask behaviour
  task automatic t_entry(input string req, input logic [7:0] spec, input logic irq,
                         input int l, input logic irq_kind);
    int w0, l0, ml0;
    logic [15:0] sp;
    sp = 16'h0800;
    mem[16'h0FFE >> 1] = 16'hC0DE ^ {8'h00, spec};
    lat = l;
    set_ctx(sp, spec, irq, 1'b0, 4'b1010);
    w0 = wn; l0 = ln;
    ml0 = 0;
    bnd_i = 1'b1;
    run_seq(req, 1 + 8 * (l + 1));
    chk("R2", "write count", wn - w0, 7);
    chk("R2", "w0 spec", {wl_addr[w0[7:0]], wl_data[w0[7:0]]}, {sp - 16'd2, 8'h00, spec});
    chk("R2", "w1 sp", {wl_addr[w0[7:0]+1], wl_data[w0[7:0]+1]}, {sp - 16'd4, sp});
    chk("R2", "w2 pc", {wl_addr[w0[7:0]+2], wl_data[w0[7:0]+2]}, {sp - 16'd6, 16'h1234});
    chk("R2", "w3 b", {wl_addr[w0[7:0]+3], wl_data[w0[7:0]+3]}, {sp - 16'd8, 16'hB00B});
    chk("R2", "w4 x", {wl_addr[w0[7:0]+4], wl_data[w0[7:0]+4]}, {sp - 16'd10, 16'h5A5A});
    chk("R2", "w5 a", {wl_addr[w0[7:0]+5], wl_data[w0[7:0]+5]}, {sp - 16'd12, 16'hA0A1});
    chk(irq_kind ? "R6" : "R2", "w6 flags word",
        {wl_addr[w0[7:0]+6], wl_data[w0[7:0]+6]}, {sp - 16'd14, 16'h000A});
    chk("R3", "pc from vector", {16'h0, v_pc}, {16'h0, 16'hC0DE ^ {8'h00, spec}});
    chk("R3", "sp new top", {16'h0, v_sp}, {16'h0, sp - 16'd14});
    for (int i = l0; i < ln; i++) if (ll_code[i[7:0]] == 6) ml0++;
    if (irq_kind) begin
      chk("R6", "mask loaded once", ml0, 1);
      chk("R6", "mask value", {31'b0, v_mask}, 32'd1);
    end else begin
      chk(irq ? "R7" : "R6", "trap leaves mask", ml0, 0);
    end
    chk("R3", "loads pc,sp(,mask)", ln - l0, irq_kind ? 3 : 2);
    lat = 0;
  endtask

  // boundary or request that must start nothing
  task automatic t_quiet(input string req, input logic [7:0] spec, input logic bnd,
                         input logic irq, input logic mask);
    int w0, l0, seen;
    set_ctx(16'h0900, spec, irq, mask, 4'b0001);
    w0 = wn; l0 = ln; seen = 0;
    bnd_i = bnd;
    #1;
    if (busy_o) seen++;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      bnd_i = 1'b0;
      if (busy_o || mem_req_o || done_o) seen++;
    end
    irq_i = 1'b0;
    chk(req, "no activity", seen, 0);
    chk(req, "no writes", wn - w0, 0);
    chk(req, "no loads", ln - l0, 0);
  endtask

  task automatic t_return(input string req, input int l, input logic mbit,
                          input logic irq);
    int l0;
    logic [15:0] sp;
    sp = 16'h0700;
    mem[(sp >> 1) + 0] = {11'b0, mbit, 4'b0101};
    mem[(sp >> 1) + 1] = 16'h1111;
    mem[(sp >> 1) + 2] = 16'h2222;
    mem[(sp >> 1) + 3] = 16'h3333;
    mem[(sp >> 1) + 4] = 16'h4444;
    mem[(sp >> 1) + 5] = 16'h0710;
    lat = l;
    set_ctx(sp, 8'h01, irq, 1'b0, 4'b0000);
    l0 = ln;
    bnd_i = 1'b1;
    run_seq(req, 1 + 6 * (l + 1));
    chk("R4", "load count", ln - l0, 7);
    chk("R4", "order flags", ll_code[l0[7:0]], 0);
    chk("R4", "order mask with flags", ll_code[l0[7:0]+1], 6);
    chk("R4", "order a", ll_code[l0[7:0]+2], 1);
    chk("R4", "order x", ll_code[l0[7:0]+3], 2);
    chk("R4", "order b", ll_code[l0[7:0]+4], 3);
    chk("R4", "order pc", ll_code[l0[7:0]+5], 4);
    chk("R4", "order sp", ll_code[l0[7:0]+6], 5);
    chk("R4", "values", {v_flags, v_a, v_x[11:0]}, {4'b0101, 16'h1111, 12'h222});
    chk("R4", "values b pc", {v_b, v_pc}, {16'h3333, 16'h4444});
    chk("R4", "value sp", {16'h0, v_sp}, {16'h0, 16'h0710});
    chk(irq ? "R7" : "R4", "mask restored", {31'b0, v_mask}, {31'b0, mbit});
    irq_i = 1'b0;
    lat = 0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    v_sp = '0; v_pc = '0; v_a = '0; v_x = '0; v_b = '0; v_flags = '0; v_mask = 1'b0;
    @(negedge clk);
    t_reset();
    t_entry("R1", 8'hE8, 1'b0, 0, 1'b0);   // opcode 11101
    t_entry("R1", 8'hF3, 1'b0, 0, 1'b0);   // opcode 11110
    t_entry("R8", 8'hFF, 1'b0, 2, 1'b0);   // opcode 11111, two wait cycles
    t_quiet("R1", 8'h50, 1'b1, 1'b0, 1'b0);
    t_quiet("R5", 8'h50, 1'b0, 1'b1, 1'b0);
    t_quiet("R5", 8'h50, 1'b1, 1'b1, 1'b1);
    t_entry("R6", 8'h50, 1'b1, 0, 1'b1);
    t_entry("R8", 8'h50, 1'b1, 1, 1'b1);
    t_entry("R7", 8'hE9, 1'b1, 0, 1'b0);
    t_return("R4", 0, 1'b1, 1'b0);
    t_return("R8", 1, 1'b0, 1'b0);
    t_return("R7", 0, 1'b0, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule